// File: doc/BRIEF.md
# Static Schedule State Counter

This block holds the step number of a controller whose schedule is fixed when the chip is built. Each cycle the surrounding controller can ask the counter to move on by one step, to go back to step zero, or to do neither. The counter keeps its step in a register. The encoding of that register is picked by a parameter: a compact binary count or a one-hot vector.

Next to the register, the block decodes a parameter list of step windows. Each window is a half-open range of steps. Its flag is high for as long as the current step falls inside the range. Downstream logic uses these flags to enable the work scheduled in that window.

The way a window is decoded depends on the encoding. In binary, a single-step window is an equality test, a window that starts at step zero is one less-than test, and any other window uses two compares. In one-hot, the flag is the OR of the register bits the window covers. When the same window appears more than once in the list, it is decoded only once and the copies are wired to that one result.

Top module: `sched_counter`

## Requirements
- R1: With binary encoding the state port is $clog2(NUM_STATES+1) bits wide, and after reset it holds the value 0.
- R2: With one-hot encoding the state port is NUM_STATES bits wide, and after reset it holds 1, meaning step 0 is hot (bit 0 set).
- R3: When neither step nor restart is high at a clock edge, the state keeps its value.
- R4: With binary encoding, step high (and restart low) adds one to the state at the next edge.
- R5: With one-hot encoding, step high (and restart low) shifts the state left by one bit at the next edge, so step k is bit k.
- R6: Restart high loads the start value at the next edge: 0 in binary, 1 in one-hot. Restart wins when step is high in the same cycle.
- R7: With binary encoding, flag q is high exactly when WIN_LO[q] <= state < WIN_HI[q]. This holds for single-step windows, for windows that start at 0, and for general windows.
- R8: With one-hot encoding, flag q is high exactly when any of state bits WIN_LO[q] through WIN_HI[q]-1 is set.
- R9: Two windows with the same bounds give identical flags on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the start step |
| step | input | 1 | Advance to the next step |
| restart | input | 1 | Return to step 0; wins over step |
| state | output | SW | Current step: binary count or one-hot vector |
| flags | output | NQ | Window membership flag for each window in the list |

## Verification
Step and restart can both be requested in the same cycle, and the result must be the start value. The bench provokes this on purpose from states far from zero, and it also lets random stimulus raise both at once. After each clock the bench compares the state of a binary instance and a one-hot instance with an integer model, in which restart overrides step. It also compares every window flag with a range test on the model step, and checks that the duplicated window always matches its twin.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [0:0] {
        ENC_BIN    = 1'b0,
        ENC_ONEHOT = 1'b1
    } enc_e;

    // Width of the state register for a given encoding and step count
    function automatic int state_width(enc_e enc, int n_steps);
        int w;
        if (enc == ENC_ONEHOT) begin
            w = n_steps;
        end else begin
            w = $clog2(n_steps + 1);
        end
        if (w < 1) w = 1;
        return w;
    endfunction

    // Binary window decode forms
    typedef enum logic [1:0] {
        WIN_EQ,
        WIN_LT,
        WIN_RANGE
    } win_form_e;

    function automatic win_form_e win_form(int lo, int hi);
        if (hi == lo + 1) return WIN_EQ;
        if (lo == 0) return WIN_LT;
        return WIN_RANGE;
    endfunction

endpackage

// File: rtl/sched_state_reg.sv
module sched_state_reg
    import sched_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN,
    parameter int   SW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          restart,
    output logic [SW-1:0] state
);
    localparam logic [SW-1:0] START = (ENC == ENC_ONEHOT) ? SW'(1) : '0;

    logic [SW-1:0] advanced;
    logic [SW-1:0] nxt;
    logic          wr_en;

    generate
        if (ENC == ENC_ONEHOT) begin : g_shift
            assign advanced = {state[SW-2:0], 1'b0};
        end else begin : g_add
            assign advanced = state + SW'(1);
        end
    endgenerate

    always_comb begin
        wr_en = restart | step;
        nxt   = restart ? START : advanced;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= START;
        end else if (wr_en) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/sched_window_flag.sv
module sched_window_flag
    import sched_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN,
    parameter int   SW  = 3,
    parameter int   LO  = 0,
    parameter int   HI  = 1
) (
    input  logic [SW-1:0] state,
    output logic          hit
);
    localparam win_form_e FORM = win_form(LO, HI);

    generate
        if (ENC == ENC_ONEHOT) begin : g_slice
            assign hit = |state[HI-1:LO];
        end else if (FORM == WIN_EQ) begin : g_eq
            assign hit = (state == SW'(LO));
        end else if (FORM == WIN_LT) begin : g_lt
            assign hit = (state < SW'(HI));
        end else begin : g_rng
            assign hit = (state >= SW'(LO)) && (state < SW'(HI));
        end
    endgenerate
endmodule

// File: rtl/sched_counter.sv
module sched_counter
    import sched_pkg::*;
#(
    parameter enc_e ENC        = ENC_BIN,
    parameter int   NUM_STATES = 6,
    parameter int   NQ         = 6,
    parameter int   WIN_LO [NQ] = '{0, 2, 3, 0, 5, 1},
    parameter int   WIN_HI [NQ] = '{2, 3, 6, 2, 6, 6},
    localparam int  SW         = state_width(ENC, NUM_STATES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          restart,
    output logic [SW-1:0] state,
    output logic [NQ-1:0] flags
);
    // Index of the first window with the same bounds as window q
    function automatic int twin_of(int q);
        for (int j = 0; j < q; j++) begin
            if (WIN_LO[j] == WIN_LO[q] && WIN_HI[j] == WIN_HI[q]) return j;
        end
        return q;
    endfunction

    sched_state_reg #(.ENC(ENC), .SW(SW)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .restart (restart),
        .state   (state)
    );

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_win
            localparam int TW = twin_of(q);
            if (!(WIN_LO[q] >= 0 && WIN_LO[q] < WIN_HI[q] && WIN_HI[q] <= NUM_STATES)) begin : g_bad
                $error("window bounds out of range");
            end
            if (TW == q) begin : g_own
                sched_window_flag #(
                    .ENC (ENC),
                    .SW  (SW),
                    .LO  (WIN_LO[q]),
                    .HI  (WIN_HI[q])
                ) u_flag (
                    .state (state),
                    .hit   (flags[q])
                );
            end else begin : g_share
                assign flags[q] = flags[TW];
            end
        end
    endgenerate
endmodule

// File: rtl/sched_counter_chk.sv
module sched_counter_chk
    import sched_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN,
    parameter int   SW  = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          step,
    input logic          restart,
    input logic [SW-1:0] state
);
    localparam logic [SW-1:0] START = (ENC == ENC_ONEHOT) ? SW'(1) : '0;

    // R1 / R2: reset lands on the start value
    a_r2_reset_start: assert property (@(posedge clk) rst |=> state == START);

    // R3: idle cycle holds the state
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !restart) |=> $stable(state));

    // R6: restart wins over step
    a_r6_restart_wins: assert property (@(posedge clk) disable iff (rst)
        restart |=> state == START);

    generate
        if (ENC == ENC_ONEHOT) begin : g_oh
            // R5: shift left by one
            a_r5_shift: assert property (@(posedge clk) disable iff (rst)
                (step && !restart) |=> state == {$past(state[SW-2:0]), 1'b0});
            // R5: never more than one bit hot
            a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
                $onehot0(state));
        end else begin : g_bin
            // R4: add one
            a_r4_incr: assert property (@(posedge clk) disable iff (rst)
                (step && !restart) |=> state == $past(state) + SW'(1));
        end
    endgenerate
endmodule

bind sched_counter sched_counter_chk #(.ENC(ENC), .SW(SW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .restart (restart),
    .state   (state)
);

// File: tb/sim_sched_counter.sv
module sim_sched_counter;
    import sched_pkg::*;

    localparam int N  = 6;
    localparam int NQ = 6;
    localparam int LO [NQ] = '{0, 2, 3, 0, 5, 1};
    localparam int HI [NQ] = '{2, 3, 6, 2, 6, 6};
    localparam int SWB = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 1'b0;
    logic restart = 1'b0;
    logic [SWB-1:0] st_b;
    logic [N-1:0]   st_o;
    logic [NQ-1:0]  fl_b, fl_o;

    int total = 0;
    int bad = 0;
    int idx = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sched_counter #(.ENC(ENC_BIN), .NUM_STATES(N), .NQ(NQ), .WIN_LO(LO), .WIN_HI(HI)) u0 (
        .clk(clk), .rst(rst), .step(step), .restart(restart), .state(st_b), .flags(fl_b));

    sched_counter #(.ENC(ENC_ONEHOT), .NUM_STATES(N), .NQ(NQ), .WIN_LO(LO), .WIN_HI(HI)) u1 (
        .clk(clk), .rst(rst), .step(step), .restart(restart), .state(st_o), .flags(fl_o));

    function automatic bit in_win(int s, int q);
        return (s >= LO[q]) && (s < HI[q]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (model step %0d)", tag, act, exp, idx);
        end
    endtask

    // Compare both instances against the model step
    task automatic check_all(string tag);
        chk({tag, " R1/R4 bin state"}, int'(st_b), idx);
        chk({tag, " R2/R5 onehot state"}, int'(st_o), 1 << idx);
        for (int q = 0; q < NQ; q++) begin
            chk({tag, " R7 bin flag"}, int'(fl_b[q]), int'(in_win(idx, q)));
            chk({tag, " R8 onehot flag"}, int'(fl_o[q]), int'(in_win(idx, q)));
        end
        chk({tag, " R9 twin bin"}, int'(fl_b[3]), int'(fl_b[0]));
        chk({tag, " R9 twin onehot"}, int'(fl_o[3]), int'(fl_o[0]));
    endtask

    // Drive at negedge, then check at the following negedge
    task automatic cyc(bit s, bit r, string tag);
        step = s;
        restart = r;
        @(negedge clk);
        if (r) idx = 0;
        else if (s) idx = idx + 1;
        check_all(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        idx = 0;
        chk("R1 width", $bits(st_b), SWB);
        chk("R2 width", $bits(st_o), N);
        check_all("reset");

        // Walk through every step
        for (int k = 1; k < N; k++) cyc(1'b1, 1'b0, "walk R4 R5");
        cyc(1'b0, 1'b0, "hold at top R3");
        cyc(1'b0, 1'b0, "hold again R3");
        // Restart and step together, from the last step
        cyc(1'b1, 1'b1, "restart+step R6");
        cyc(1'b1, 1'b0, "step R4");
        cyc(1'b1, 1'b0, "step R4");
        cyc(1'b1, 1'b1, "restart+step mid R6");
        cyc(1'b0, 1'b1, "restart at zero R6");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            bit s, r;
            s = ($urandom % 3) != 0;
            r = ($urandom % 8) == 0;
            if (idx >= N - 1 && !r) s = 1'b0;
            cyc(s, r, "random");
        end

        // Reset mid-run
        cyc(1'b1, 1'b0, "pre-reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idx = 0;
        check_all("re-reset R1 R2");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule